// File: doc/BRIEF.md
# Tunable Chroma Subcarrier Oscillator

This block is a numerically controlled oscillator that makes the colour subcarrier for a composite or Y/C video encoder. It runs on the fast video pixel clock and keeps a 40-bit phase accumulator. The upper 8 bits of the accumulator select a step of one waveform cycle, and the lower 32 bits hold the fraction. On every clock the accumulator adds an increment. That increment is the nominal value for the wanted subcarrier, given as the subcarrier frequency times 2^40 divided by the video clock frequency. For example, 3.579545 MHz from a 107.38635 MHz clock gives 36650387593.

A small runtime trim can raise or lower the nominal increment so that the subcarrier can be tuned to remove dot crawl. The trim is a 5-bit magnitude shifted left by a 5-bit exponent. A direction bit chooses whether the shifted value is added to or subtracted from the base increment. The 8-bit phase index reads a 256-entry signed sine table. This gives quadrature sine and cosine samples, which a later modulator stage combines with the colour-difference signals.

Top module: `subcar_nco`

## Requirements
- R1: While `rst` is high at a rising edge, the phase word is cleared to 0 and both samples are cleared to 0 after that edge.
- R2: The effective increment is `base_inc + (trim_mag << trim_exp)` when `trim_rev` is 0 and `base_inc - (trim_mag << trim_exp)` when `trim_rev` is 1, taken modulo 2^40. It is registered once, so inputs present at edge t set the phase step taken at edge t+1.
- R3: At every rising edge with `rst` low, `phase` becomes (previous `phase` + registered increment) mod 2^40.
- R4: With a constant `base_inc`, zero trim magnitude and `rst` released, `phase` after k rising edges equals k × `base_inc` mod 2^40. The increment register keeps loading while reset is held.
- R5: `sin_out` is a two's-complement 8-bit value equal to round(127 · sin(2π·i/256)), where i is `phase[39:32]` as it stood before the edge that produced the sample. The value −128 never appears.
- R6: `cos_out` uses the same table at index (i + 64) mod 256, so that its magnitude together with `sin_out` stays on the circle of radius 127, within rounding.
- R7: A subtracted trim that is larger than the base wraps below zero modulo 2^40, and an added trim that carries past 2^40 wraps the same way.
- R8: The largest trim, magnitude 31 with exponent 31 (31·2^31), is applied exactly, with no bit lost.
- R9: A zero effective increment holds `phase` constant, and the samples then stay constant one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| base_inc | input | 40 | Nominal phase increment per clock |
| trim_mag | input | 5 | Trim magnitude, 0 to 31 |
| trim_exp | input | 5 | Left-shift exponent for the trim, 0 to 31 |
| trim_rev | input | 1 | 1 subtracts the trim, 0 adds it |
| phase | output | 40 | Current accumulator value (direct from the accumulator register) |
| sin_out | output | 8 | Signed sine sample of the previous phase index |
| cos_out | output | 8 | Signed cosine sample of the previous phase index |

## Verification
A change of trim settings can land in the same cycle in which the accumulator wraps past 2^40. In that cycle the old registered step must finish the wrap, and the new step must take effect only from the next edge. The bench provokes this by driving a large base increment near full scale. It then rewrites the magnitude, exponent and direction on every cycle from a shift-register sequence, so that carries out of bit 39 and trim updates keep falling together. A behavioural model, advanced on each rising edge, predicts the phase and both samples, and the outputs are compared at every falling edge.

// File: rtl/subcar_pkg.sv
package subcar_pkg;

    localparam int TMAG_W = 5;
    localparam int TEXP_W = 5;

    typedef enum logic {
        TRIM_ADD = 1'b0,
        TRIM_SUB = 1'b1
    } trim_dir_e;

    typedef struct packed {
        trim_dir_e            dir;
        logic [TEXP_W-1:0]    shamt;
        logic [TMAG_W-1:0]    mag;
    } trim_t;

    // Rounded signed sine amplitude for table entry k of 2**idx_w entries.
    function automatic int sine_at(input int k, input int idx_w, input int samp_w);
        real amp;
        real ang;
        real val;
        amp = (2.0 ** (samp_w - 1)) - 1.0;
        ang = 2.0 * 3.14159265358979323846 * real'(k) / (2.0 ** idx_w);
        val = amp * $sin(ang);
        return $rtoi($floor(val + 0.5));
    endfunction

endpackage

// File: rtl/subcar_inc.sv
module subcar_inc
    import subcar_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic               clk,
    input  logic [ACC_W-1:0]   base,
    input  trim_t              trim,
    output logic [ACC_W-1:0]   inc_q
);

    logic [ACC_W-1:0] scaled;
    logic [ACC_W-1:0] eff;

    always_comb begin
        scaled = ACC_W'(trim.mag) << trim.shamt;
        if (trim.dir == TRIM_SUB) begin
            eff = base - scaled;
        end else begin
            eff = base + scaled;
        end
    end

    // Loads every cycle, including under reset, so the step is ready at release.
    always_ff @(posedge clk) begin
        inc_q <= eff;
    end

endmodule

// File: rtl/subcar_acc.sv
module subcar_acc #(
    parameter int ACC_W = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ACC_W-1:0]   inc,
    output logic [ACC_W-1:0]   acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            acc <= acc + inc;
        end
    end

endmodule

// File: rtl/subcar_wave.sv
module subcar_wave
    import subcar_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int SAMP_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          idx,
    output logic signed [SAMP_W-1:0]  sin_q,
    output logic signed [SAMP_W-1:0]  cos_q
);

    localparam int DEPTH   = 1 << IDX_W;
    localparam int QUARTER = DEPTH / 4;
    localparam int NCH     = 2;

    logic signed [SAMP_W-1:0] rom [DEPTH];
    logic signed [SAMP_W-1:0] samp_d [NCH];
    logic signed [SAMP_W-1:0] samp_q [NCH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_rom
        localparam int VAL = sine_at(k, IDX_W, SAMP_W);
        assign rom[k] = SAMP_W'(VAL);
    end

    // Channel 0 reads the sine phase, channel 1 reads a quarter turn ahead.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [IDX_W-1:0] OFS = IDX_W'(c * QUARTER);
        logic [IDX_W-1:0] addr;
        assign addr      = idx + OFS;
        assign samp_d[c] = rom[addr];
        always_ff @(posedge clk) begin
            if (rst) begin
                samp_q[c] <= '0;
            end else begin
                samp_q[c] <= samp_d[c];
            end
        end
    end

    assign sin_q = samp_q[0];
    assign cos_q = samp_q[1];

endmodule

// File: rtl/subcar_nco.sv
module subcar_nco
    import subcar_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int IDX_W  = 8,
    parameter int SAMP_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ACC_W-1:0]          base_inc,
    input  logic [TMAG_W-1:0]         trim_mag,
    input  logic [TEXP_W-1:0]         trim_exp,
    input  logic                      trim_rev,
    output logic [ACC_W-1:0]          phase,
    output logic signed [SAMP_W-1:0]  sin_out,
    output logic signed [SAMP_W-1:0]  cos_out
);

    localparam int FRAC_W = ACC_W - IDX_W;

    trim_t            trim;
    logic [ACC_W-1:0] inc_q;
    logic [ACC_W-1:0] acc;

    always_comb begin
        trim.mag   = trim_mag;
        trim.shamt = trim_exp;
        trim.dir   = trim_rev ? TRIM_SUB : TRIM_ADD;
    end

    subcar_inc #(.ACC_W(ACC_W)) u_inc (
        .clk   (clk),
        .base  (base_inc),
        .trim  (trim),
        .inc_q (inc_q)
    );

    subcar_acc #(.ACC_W(ACC_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .inc (inc_q),
        .acc (acc)
    );

    subcar_wave #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_wave (
        .clk   (clk),
        .rst   (rst),
        .idx   (acc[ACC_W-1:FRAC_W]),
        .sin_q (sin_out),
        .cos_q (cos_out)
    );

    assign phase = acc;

endmodule

// File: rtl/subcar_nco_chk.sv
module subcar_nco_chk
    import subcar_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int SAMP_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ACC_W-1:0]          base_inc,
    input  logic [TMAG_W-1:0]         trim_mag,
    input  logic [TEXP_W-1:0]         trim_exp,
    input  logic                      trim_rev,
    input  logic [ACC_W-1:0]          phase,
    input  logic signed [SAMP_W-1:0]  sin_out,
    input  logic signed [SAMP_W-1:0]  cos_out
);

    localparam int AMP = (1 << (SAMP_W - 1)) - 1;

    logic [1:0] edges = 2'd0;
    logic       rst_d = 1'b0;

    always_ff @(posedge clk) begin
        if (edges != 2'd3) edges <= edges + 2'd1;
        rst_d <= rst;
    end

    function automatic logic [ACC_W-1:0] want_step(input logic [ACC_W-1:0] b,
                                                   input logic [TMAG_W-1:0] m,
                                                   input logic [TEXP_W-1:0] e,
                                                   input logic r);
        logic [ACC_W-1:0] s;
        s = ACC_W'(m) << e;
        return r ? (b - s) : (b + s);
    endfunction

    // R1: after a reset edge everything reads zero
    always_ff @(negedge clk) begin
        if (rst_d) begin
            a_r1_reset_clear: assert (phase == '0 && sin_out == '0 && cos_out == '0)
                else $error("reset did not clear outputs");
        end
    end

    // R2, R3: phase step equals trim-adjusted base seen two edges back
    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (edges == 2'd3 && !$past(rst)) |->
        (phase - $past(phase) == want_step($past(base_inc, 2), $past(trim_mag, 2),
                                           $past(trim_exp, 2), $past(trim_rev, 2))));

    // R9: frozen phase gives frozen samples one cycle later
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (edges == 2'd3 && !$past(rst) && $stable(phase)) |=>
        ($stable(sin_out) && $stable(cos_out)));

    // R5: symmetric amplitude, most negative code unused
    a_r5_amp_bound: assert property (@(posedge clk) disable iff (rst)
        (sin_out != -(AMP + 1)) && (cos_out != -(AMP + 1)));

    // R6: sine and cosine stay on the circle within rounding
    a_r6_quadrature: assert property (@(posedge clk) disable iff (rst)
        (edges == 2'd3 && !$past(rst)) |->
        ((int'(sin_out) * int'(sin_out) + int'(cos_out) * int'(cos_out) >= (AMP - 2) * (AMP - 2)) &&
         (int'(sin_out) * int'(sin_out) + int'(cos_out) * int'(cos_out) <= (AMP + 2) * (AMP + 2))));

endmodule

bind subcar_nco subcar_nco_chk #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_chk (.*);

// File: tb/subcar_nco_bench.sv
module subcar_nco_bench;

    localparam int  CLK_PERIOD = 10;
    localparam int  ACC_W      = 40;
    localparam longint unsigned MASK = (64'd1 << ACC_W) - 64'd1;
    localparam longint unsigned NTSC_INC = 64'd36650387593;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [ACC_W-1:0]    base_inc = '0;
    logic [4:0]          trim_mag = '0;
    logic [4:0]          trim_exp = '0;
    logic                trim_rev = 1'b0;
    logic [ACC_W-1:0]    phase;
    logic signed [7:0]   sin_out;
    logic signed [7:0]   cos_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 1'b0;

    longint unsigned m_acc = 0;
    longint unsigned m_inc = 0;
    int              m_sin = 0;
    int              m_cos = 0;

    subcar_nco u_subcar_nco (
        .clk(clk), .rst(rst), .base_inc(base_inc), .trim_mag(trim_mag),
        .trim_exp(trim_exp), .trim_rev(trim_rev), .phase(phase),
        .sin_out(sin_out), .cos_out(cos_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int tab(input int k);
        real x;
        x = 127.0 * $sin(2.0 * 3.14159265358979323846 * real'(k % 256) / 256.0);
        return $rtoi($floor(x + 0.5));
    endfunction

    function automatic longint unsigned step_of(input longint unsigned b, input int m,
                                                input int e, input bit r);
        longint unsigned s;
        s = longint'(m) << e;
        return (r ? (b - s) : (b + s)) & MASK;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference advanced on each rising edge
    always @(posedge clk) begin
        int idx;
        model_on = 1'b1;
        idx = int'((m_acc >> 32) & 64'hFF);
        if (rst) begin
            m_acc = 0; m_sin = 0; m_cos = 0;
        end else begin
            m_sin = tab(idx);
            m_cos = tab(idx + 64);
            m_acc = (m_acc + m_inc) & MASK;
        end
        m_inc = step_of(base_inc, int'(trim_mag), int'(trim_exp), trim_rev);
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // R3 R5 R6: every-cycle comparison
    always @(negedge clk) begin
        if (model_on) begin
            check(longint'(phase) == longint'(m_acc), "R3 phase", longint'(phase), longint'(m_acc));
            check(int'(sin_out) == m_sin, "R5 sin", int'(sin_out), m_sin);
            check(int'(cos_out) == m_cos, "R6 cos", int'(cos_out), m_cos);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic set_trim(input int m, input int e, input bit r);
        trim_mag = 5'(m); trim_exp = 5'(e); trim_rev = r;
    endtask

    task automatic measure(input longint unsigned exp, input string req);
        longint unsigned p0, d;
        tick(2);
        p0 = longint'(phase);
        tick(1);
        d = (longint'(phase) - p0) & MASK;
        check(d == exp, req, longint'(d), longint'(exp));
    endtask

    initial begin
        longint unsigned lfsr;
        base_inc = ACC_W'(NTSC_INC);
        tick(3);
        // R1: held reset
        check(phase == '0 && sin_out == 0 && cos_out == 0, "R1 reset", longint'(phase), 0);
        rst = 1'b0;
        tick(1000);
        // R4: k edges of pure base
        check(longint'(phase) == ((NTSC_INC * 1000) & MASK), "R4 k*base",
              longint'(phase), longint'((NTSC_INC * 1000) & MASK));

        // R2: add and subtract trim paths
        set_trim(17, 9, 1'b0);
        measure(step_of(NTSC_INC, 17, 9, 1'b0), "R2 add");
        set_trim(17, 9, 1'b1);
        measure(step_of(NTSC_INC, 17, 9, 1'b1), "R2 sub");
        set_trim(0, 31, 1'b1);
        measure(NTSC_INC, "R2 zero mag");

        // R8: largest trim applied exactly
        set_trim(31, 31, 1'b0);
        measure((NTSC_INC + (64'd31 << 31)) & MASK, "R8 max add");

        // R7: overflow and underflow of the step
        base_inc = ACC_W'(MASK - 4);
        set_trim(31, 31, 1'b0);
        measure(step_of(MASK - 4, 31, 31, 1'b0), "R7 carry wrap");
        base_inc = ACC_W'(100);
        set_trim(31, 31, 1'b1);
        measure(step_of(100, 31, 31, 1'b1), "R7 borrow wrap");

        // Trim changes colliding with accumulator wraps
        base_inc = ACC_W'(MASK - 64'd12345);
        lfsr = 64'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59] ^ 1'b1};
            set_trim(int'(lfsr[4:0]), int'(lfsr[9:5]), lfsr[10]);
            tick(1);
        end

        // R5 R6: unit index step through table landmarks
        set_trim(0, 0, 1'b0);
        base_inc = ACC_W'(64'd1 << 32);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        check(sin_out == 0 && cos_out == 127, "R6 idx0", int'(cos_out), 127);
        tick(64);
        check(sin_out == 127 && cos_out == 0, "R5 idx64", int'(sin_out), 127);
        tick(128);
        check(sin_out == -127 && cos_out == 0, "R5 idx192", int'(sin_out), -127);

        // R9: zero step freezes phase and samples
        base_inc = '0;
        tick(3);
        begin
            longint unsigned p0;
            int s0;
            p0 = longint'(phase);
            s0 = int'(sin_out);
            tick(5);
            check(longint'(phase) == p0, "R9 phase hold", longint'(phase), longint'(p0));
            check(int'(sin_out) == s0, "R9 sin hold", int'(sin_out), s0);
        end

        // R1: reset mid-run
        base_inc = ACC_W'(NTSC_INC);
        tick(20);
        rst = 1'b1;
        tick(1);
        check(phase == '0 && sin_out == 0 && cos_out == 0, "R1 mid reset", longint'(phase), 0);
        rst = 1'b0;
        tick(7);
        check(longint'(phase) == ((NTSC_INC * 7) & MASK), "R4 after reset",
              longint'(phase), longint'((NTSC_INC * 7) & MASK));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule